// File: doc/BRIEF.md
# Interrupt Request Qualification Front End

This block sits between the raw interrupt request lines of a system and the processor core's interrupt sequencer. It brings two asynchronous requests into the clock domain. The first is a maskable request that is active while held high. The second is a non-maskable request that counts only on a clean rising edge. The block qualifies both requests and presents the core with one pending flag and a cause code.

The maskable request is gated by the core's interrupt-enable flag. The non-maskable request is not gated by that flag. Once a non-maskable event has been seen, it is latched and held until the core clears it explicitly.

When the core takes an interrupt while the maskable cause is the one reported, the block pulls an active-low acknowledge strobe for one clock so that the requesting device can respond. A non-maskable event is never acknowledged toward a device. It always takes precedence over the maskable request.

Top module: `irq_front_end`

## Requirements
- R1: `cause_o` encodes the reported source as 2'b00 = none, 2'b01 = non-maskable and 2'b10 = maskable. `pending_o` is 1 exactly when `cause_o` is not 2'b00.
- R2: `mreq_i` is active high and level sensitive, and passes through a two-flop synchroniser. A change on it is visible on `pending_o`/`cause_o` after the second rising clock edge following the change, provided `int_en_i` is 1.
- R3: A rising edge on `nmi_i` passes through a two-flop synchroniser and is latched. From the third rising clock edge after the raw rise, `cause_o` reads 2'b01, whatever `int_en_i` holds.
- R4: A non-maskable rise is accepted only if the synchronised input was sampled low on at least two consecutive clocks immediately before it. Because of this, a one-clock low dip between high periods is not an event.
- R5: While `int_en_i` is 0, the maskable request is ignored. It does not make `pending_o` high, it does not appear in `cause_o`, and a `take_i` pulse then produces no acknowledge.
- R6: A latched non-maskable event stays reported until a `nmi_clr_i` pulse. Further edges that arrive while it is latched merge into it, so one clear removes it. A new accepted edge in the same cycle as a clear keeps the event latched.
- R7: When both requests are active, `cause_o` reports 2'b01. A `take_i` pulse in that state produces no acknowledge.
- R8: `take_i` while `cause_o` is 2'b10 drives `ack_n_o` low for exactly one clock, starting at the next clock edge. A `take_i` in the cycle during which `ack_n_o` is low is not accepted.
- R9: During and right after reset, `pending_o` is 0, `cause_o` is 2'b00 and `ack_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_i | input | 1 | Raw maskable request, level, active high |
| nmi_i | input | 1 | Raw non-maskable request, rising edge |
| int_en_i | input | 1 | Core interrupt-enable flag |
| take_i | input | 1 | Core takes the reported interrupt (pulse) |
| nmi_clr_i | input | 1 | Core clears the latched non-maskable event (pulse) |
| pending_o | output | 1 | An interrupt is pending |
| cause_o | output | 2 | Reported cause code |
| ack_n_o | output | 1 | Active-low acknowledge strobe to the maskable requester |

## Verification
On every cycle, the assertions check several invariants: the agreement between the pending flag and the cause code, the masking of the maskable cause while the enable flag is low, the single-clock width of the acknowledge and the fact that it is always preceded by a take of a maskable cause, and the persistence of a latched non-maskable event until it is cleared. The bench's scenarios are needed to show the things that depend on history across many cycles. These are the exact synchroniser latencies, the rejection of a rise that follows too short a low period, the merging of repeated edges, and the interplay of clear and edge in the same cycle. A cycle-level reference model driven by mixed random and directed stimulus covers those.

// File: rtl/irq_front_end.sv
module irq_front_end #(
  parameter int LOW_MIN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mreq_i,
  input  logic       nmi_i,
  input  logic       int_en_i,
  input  logic       take_i,
  input  logic       nmi_clr_i,
  output logic       pending_o,
  output logic [1:0] cause_o,
  output logic       ack_n_o
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam logic [1:0] C_NONE = 2'b00;
  localparam logic [1:0] C_NMI  = 2'b01;
  localparam logic [1:0] C_MASK = 2'b10;
  localparam logic [LW-1:0] LOW_SAT = LW'(LOW_MIN);

  logic [1:0]    m_sy, n_sy;
  logic [LW-1:0] low_run;
  logic          nmi_lat;

  wire nmi_edge = n_sy[1] && (low_run >= LOW_SAT);
  wire m_qual   = m_sy[1] && int_en_i;
  wire accept   = take_i && m_qual && !nmi_lat && ack_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sy    <= '0;
      n_sy    <= '0;
      low_run <= '0;
      nmi_lat <= 1'b0;
      ack_n_o <= 1'b1;
    end else begin
      m_sy    <= {m_sy[0], mreq_i};
      n_sy    <= {n_sy[0], nmi_i};
      low_run <= n_sy[1] ? '0 : ((low_run == LOW_SAT) ? low_run : low_run + 1'b1);
      nmi_lat <= nmi_edge || (nmi_lat && !nmi_clr_i);
      ack_n_o <= !accept;
    end
  end

  assign cause_o   = nmi_lat ? C_NMI : (m_qual ? C_MASK : C_NONE);
  assign pending_o = nmi_lat || m_qual;

  assert_pending_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o == (cause_o != C_NONE));

  assert_mask_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en_i |-> cause_o != C_MASK);

  assert_nmi_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == C_NMI && !nmi_clr_i) |=> cause_o == C_NMI);

  assert_ack_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |=> ack_n_o);

  assert_ack_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n_o) |-> ($past(take_i) && $past(cause_o) == C_MASK));

  assert_no_ack_nmi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == C_NMI) |=> ack_n_o);
endmodule

// File: tb/test_irq_front_end.sv
module test_irq_front_end;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mreq = 1'b0, nmi = 1'b0, en = 1'b0, take = 1'b0, clr = 1'b0;
  logic       pending, ack_n;
  logic [1:0] cause;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [1:0] rm, rn;
  int         rlow;
  logic       rlat, rack;

  always #5 clk = ~clk;

  irq_front_end i_irq_front_end (
    .clk(clk), .rst_n(rst_n), .mreq_i(mreq), .nmi_i(nmi), .int_en_i(en),
    .take_i(take), .nmi_clr_i(clr), .pending_o(pending), .cause_o(cause),
    .ack_n_o(ack_n));

  function automatic logic [1:0] exp_cause();
    if (rlat) return 2'b01;
    if (rm[1] && en) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    rm = '0; rn = '0; rlow = 0; rlat = 1'b0; rack = 1'b1;
  endtask

  task automatic model_step();
    logic acc, edg;
    acc  = take && rm[1] && en && !rlat && rack;
    edg  = rn[1] && (rlow >= 2);
    rlat = edg || (rlat && !clr);
    rlow = rn[1] ? 0 : ((rlow == 2) ? 2 : rlow + 1);
    rn   = {rn[0], nmi};
    rm   = {rm[0], mreq};
    rack = !acc;
  endtask

  task automatic cyc(input logic m, input logic n, input logic e, input logic t,
                     input logic c, input string tag);
    mreq = m; nmi = n; en = e; take = t; clr = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " R1 cause"}, cause, exp_cause());
    check({tag, " R1 pending"}, {1'b0, pending}, {1'b0, exp_cause() != 2'b00});
    check({tag, " ack"}, {1'b0, ack_n}, {1'b0, rack});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    check("R9 pending", {1'b0, pending}, 2'b00);
    check("R9 cause", cause, 2'b00);
    check("R9 ack", {1'b0, ack_n}, 2'b01);
    rst_n = 1'b1;
    cyc(0, 0, 1, 0, 0, "R9");
    check("R9 ack after release", {1'b0, ack_n}, 2'b01);

    // maskable level latency
    cyc(1, 0, 1, 0, 0, "R2");
    check("R2 one edge", cause, 2'b00);
    cyc(1, 0, 1, 0, 0, "R2");
    check("R2 two edges", cause, 2'b10);

    // acknowledge
    cyc(1, 0, 1, 1, 0, "R8");
    check("R8 ack low", {1'b0, ack_n}, 2'b00);
    cyc(1, 0, 1, 1, 0, "R8");
    check("R8 back-to-back take ignored", {1'b0, ack_n}, 2'b01);
    cyc(1, 0, 1, 1, 0, "R8");
    check("R8 ack again", {1'b0, ack_n}, 2'b00);
    cyc(1, 0, 1, 0, 0, "R8");

    // masking
    cyc(1, 0, 0, 0, 0, "R5");
    check("R5 masked", {1'b0, pending}, 2'b00);
    cyc(1, 0, 0, 1, 0, "R5");
    check("R5 no ack", {1'b0, ack_n}, 2'b01);

    // non-maskable edge, enable off
    cyc(0, 1, 0, 0, 0, "R3");
    cyc(0, 1, 0, 0, 0, "R3");
    check("R3 two edges", cause, 2'b00);
    cyc(0, 1, 0, 0, 0, "R3");
    check("R3 three edges", cause, 2'b01);

    // priority
    cyc(1, 1, 1, 0, 0, "R7");
    cyc(1, 1, 1, 0, 0, "R7");
    check("R7 nmi first", cause, 2'b01);
    cyc(1, 1, 1, 1, 0, "R7");
    check("R7 no ack", {1'b0, ack_n}, 2'b01);

    // merge then single clear
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, 0, "R6");
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 0, "R6");
    check("R6 still nmi", cause, 2'b01);
    cyc(1, 1, 1, 0, 1, "R6");
    check("R6 one clear", cause, 2'b10);
    cyc(1, 1, 1, 0, 0, "R6");
    check("R6 stays cleared", cause, 2'b10);

    // short low dip
    cyc(0, 0, 1, 0, 0, "R4");
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 0, 0, "R4");
    check("R4 dip rejected", cause, 2'b00);
    cyc(0, 0, 1, 0, 0, "R4");
    cyc(0, 0, 1, 0, 0, "R4");
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 0, "R4");
    check("R4 two lows accepted", cause, 2'b01);
    cyc(0, 1, 1, 0, 1, "R4");

    // random
    for (int i = 0; i < 4000; i++) begin
      logic m, n, e, t, c;
      m = ($urandom_range(0, 9) < 2) ? !mreq : mreq;
      n = ($urandom_range(0, 9) < 3) ? !nmi : nmi;
      e = ($urandom_range(0, 9) < 8);
      t = ($urandom_range(0, 9) < 3);
      c = ($urandom_range(0, 9) < 1);
      cyc(m, n, e, t, c, "R3 R6 R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule